// File: doc/BRIEF.md
# Tagged Branch Target Buffer

This block sits beside the fetch stage and turns the current fetch address into the address to fetch next. It is a direct-mapped table. A few low-order bits of the fetch address, taken just above the instruction byte offset, pick one slot. Each slot holds three things: a valid flag, the complete address of a control-transfer instruction, and the address that instruction last went to. If the selected slot is valid and its stored address equals the fetch address, the lookup is a hit and the block returns the stored destination. Any other case is a miss, and the block returns the fetch address plus one instruction width.

The table only ever holds transfers that were actually taken. A hit therefore means "redirect", and no separate direction state is kept. Branch resolution writes to the table one cycle at a time through the update port. A taken branch or jump claims its slot and overwrites whatever was there before. A branch that resolves not taken removes its own entry, but only if that entry is currently present. The lookup path is purely combinational from the stored state, and updates take effect at the clock edge.

Top module: `branch_target_buffer`

## Requirements
- R1: While reset is asserted, and in every cycle after it until an update lands, every lookup misses (`pred_hit`=0).
- R2: On a miss, `next_pc` equals `fetch_pc` + INSTR_BYTES (4 by default) and `pred_hit` is 0.
- R3: An update with `upd_valid`=1 and `upd_taken`=1 stores `upd_pc` and `upd_target` at the next edge. From the following cycle, a lookup of `upd_pc` hits and returns `upd_target`.
- R4: The slot index is `pc[OFS_W+IDX_W-1:OFS_W]`, with OFS_W = log2(INSTR_BYTES) = 2 and IDX_W = 4 by default. A fetch address that selects an occupied slot but differs from the stored address misses.
- R5: A taken update replaces the previous entry in its slot. After it, the earlier address that shared the slot misses.
- R6: An update with `upd_valid`=1 and `upd_taken`=0 whose `upd_pc` equals the stored address of a valid entry invalidates that entry. A later lookup of that address misses.
- R7: A not-taken update whose address differs from the stored address in its slot leaves that entry intact.
- R8: When a lookup and an update address the same slot in one cycle, the lookup returns the contents from before the update.
- R9: With `upd_valid`=0, the update inputs have no effect on later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all valid flags |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| next_pc | output | PC_W | Predicted next fetch address |
| pred_hit | output | 1 | 1 when a valid matching entry redirects fetch |
| upd_valid | input | 1 | An update from branch resolution is present |
| upd_pc | input | PC_W | Address of the resolved control transfer |
| upd_target | input | PC_W | Resolved destination address |
| upd_taken | input | 1 | 1 for a taken branch or jump, 0 for not taken |

## Verification
The assertions assume that the update inputs are stable and known whenever `upd_valid` is high. They also assume `fetch_pc` is a settled value, so the hit flag is a function of the current address and the stored state only. The bench drives every input on the falling edge and holds it steady across the rising edge. The directed cases pick addresses that are aligned to the instruction width. The random phase draws from a small address pool, so that slot sharing, replacement and clearing happen often while every address stays aligned.

// File: rtl/btb_pkg.sv
package btb_pkg;
   parameter int unsigned DEF_PC_W        = 32;
   parameter int unsigned DEF_IDX_W       = 4;
   parameter int unsigned DEF_INSTR_BYTES = 4;

   typedef enum logic [1:0] {
      UK_NONE = 2'd0,
      UK_FILL = 2'd1,
      UK_DROP = 2'd2
   } upd_kind_e;

   function automatic upd_kind_e decode_upd(input logic valid, input logic taken);
      if (!valid)     return UK_NONE;
      else if (taken) return UK_FILL;
      else            return UK_DROP;
   endfunction
endpackage

// File: rtl/btb_index.sv
module btb_index #(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned IDX_W = 4,
   parameter int unsigned OFS_W = 2
) (
   input  logic [PC_W-1:0]  pc,
   output logic [IDX_W-1:0] idx
);
   logic unused_pc_bits;
   assign unused_pc_bits = ^pc;

   generate
      if (OFS_W == 0) begin : g_no_ofs
         assign idx = pc[IDX_W-1:0];
      end else begin : g_ofs
         assign idx = pc[OFS_W+IDX_W-1:OFS_W];
      end
   endgenerate
endmodule

// File: rtl/btb_store.sv
module btb_store #(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic [PC_W-1:0]  rd_tag,
   output logic [PC_W-1:0]  rd_tgt,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_fill,
   input  logic             wr_drop,
   input  logic [PC_W-1:0]  wr_tag,
   input  logic [PC_W-1:0]  wr_tgt
);
   localparam int unsigned ENTRIES = 1 << IDX_W;

   logic            slot_valid [ENTRIES];
   logic [PC_W-1:0] slot_tag   [ENTRIES];
   logic [PC_W-1:0] slot_tgt   [ENTRIES];

   generate
      for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
         logic            v_q;
         logic [PC_W-1:0] tag_q;
         logic [PC_W-1:0] tgt_q;
         logic            sel;
         logic            kill;

         assign sel  = (wr_idx == IDX_W'(e));
         assign kill = sel && wr_drop && v_q && (tag_q == wr_tag);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               v_q <= 1'b0;
            else if (sel && wr_fill)  v_q <= 1'b1;
            else if (kill)            v_q <= 1'b0;
         end

         always_ff @(posedge clk) begin
            if (sel && wr_fill) begin
               tag_q <= wr_tag;
               tgt_q <= wr_tgt;
            end
         end

         assign slot_valid[e] = v_q;
         assign slot_tag[e]   = tag_q;
         assign slot_tgt[e]   = tgt_q;
      end
   endgenerate

   assign rd_valid = slot_valid[rd_idx];
   assign rd_tag   = slot_tag[rd_idx];
   assign rd_tgt   = slot_tgt[rd_idx];
endmodule

// File: rtl/btb_nextpc.sv
module btb_nextpc #(
   parameter int unsigned PC_W        = 32,
   parameter int unsigned INSTR_BYTES = 4
) (
   input  logic [PC_W-1:0] fetch_pc,
   input  logic            ent_valid,
   input  logic [PC_W-1:0] ent_tag,
   input  logic [PC_W-1:0] ent_tgt,
   output logic            hit,
   output logic [PC_W-1:0] next_pc
);
   localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

   logic [PC_W-1:0] seq_pc;

   always_comb begin
      seq_pc  = fetch_pc + STEP;
      hit     = ent_valid && (ent_tag == fetch_pc);
      next_pc = hit ? ent_tgt : seq_pc;
   end
endmodule

// File: rtl/branch_target_buffer.sv
module branch_target_buffer
   import btb_pkg::*;
#(
   parameter int unsigned PC_W        = DEF_PC_W,
   parameter int unsigned IDX_W       = DEF_IDX_W,
   parameter int unsigned INSTR_BYTES = DEF_INSTR_BYTES
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] fetch_pc,
   output logic [PC_W-1:0] next_pc,
   output logic            pred_hit,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic [PC_W-1:0] upd_target,
   input  logic            upd_taken
);
   localparam int unsigned OFS_W = (INSTR_BYTES <= 1) ? 0 : $clog2(INSTR_BYTES);

   generate
      if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
         $error("IDX_W must lie in 1..12");
      end
      if ((1 << OFS_W) != INSTR_BYTES) begin : g_bad_step
         $error("INSTR_BYTES must be a power of two");
      end
      if (PC_W <= OFS_W + IDX_W) begin : g_bad_pc
         $error("PC_W must exceed the offset and index bits");
      end
   endgenerate

   logic [IDX_W-1:0] look_idx;
   logic [IDX_W-1:0] upd_idx;
   logic             ent_valid;
   logic [PC_W-1:0]  ent_tag;
   logic [PC_W-1:0]  ent_tgt;
   upd_kind_e        kind;

   assign kind = decode_upd(upd_valid, upd_taken);

   btb_index #(.PC_W(PC_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_look_idx (
      .pc  (fetch_pc),
      .idx (look_idx)
   );

   btb_index #(.PC_W(PC_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_upd_idx (
      .pc  (upd_pc),
      .idx (upd_idx)
   );

   btb_store #(.PC_W(PC_W), .IDX_W(IDX_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (look_idx),
      .rd_valid (ent_valid),
      .rd_tag   (ent_tag),
      .rd_tgt   (ent_tgt),
      .wr_idx   (upd_idx),
      .wr_fill  (kind == UK_FILL),
      .wr_drop  (kind == UK_DROP),
      .wr_tag   (upd_pc),
      .wr_tgt   (upd_target)
   );

   btb_nextpc #(.PC_W(PC_W), .INSTR_BYTES(INSTR_BYTES)) u_nextpc (
      .fetch_pc  (fetch_pc),
      .ent_valid (ent_valid),
      .ent_tag   (ent_tag),
      .ent_tgt   (ent_tgt),
      .hit       (pred_hit),
      .next_pc   (next_pc)
   );
endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
   parameter int unsigned PC_W        = 32,
   parameter int unsigned INSTR_BYTES = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic [PC_W-1:0] fetch_pc,
   input logic [PC_W-1:0] next_pc,
   input logic            pred_hit,
   input logic            upd_valid,
   input logic [PC_W-1:0] upd_pc,
   input logic [PC_W-1:0] upd_target,
   input logic            upd_taken
);
   // R1: first cycle after reset release sees an empty table
   a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> !pred_hit);

   // R2: a miss falls through to the sequential address
   a_r2_miss_sequential: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_hit |-> next_pc == fetch_pc + PC_W'(INSTR_BYTES));

   // R3: a taken update is visible on the next cycle
   a_r3_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_taken) |=>
         ((fetch_pc != $past(upd_pc)) || (pred_hit && next_pc == $past(upd_target))));

   // R6: a not-taken update leaves its address missing
   a_r6_drop_removes: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_taken) |=> ((fetch_pc != $past(upd_pc)) || !pred_hit));
endmodule

bind branch_target_buffer btb_checker #(.PC_W(PC_W), .INSTR_BYTES(INSTR_BYTES)) u_btb_checker (.*);

// File: tb/test_branch_target_buffer.sv
`timescale 1ns/1ps
module test_branch_target_buffer;
   localparam int PC_W = 32;
   localparam int SLOTS = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [PC_W-1:0] fetch_pc = '0;
   logic [PC_W-1:0] next_pc;
   logic            pred_hit;
   logic            upd_valid = 1'b0;
   logic [PC_W-1:0] upd_pc = '0;
   logic [PC_W-1:0] upd_target = '0;
   logic            upd_taken = 1'b0;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 0;

   // behavioural model
   bit              m_v   [SLOTS];
   logic [PC_W-1:0] m_tag [SLOTS];
   logic [PC_W-1:0] m_tgt [SLOTS];

   always #4 clk = ~clk;

   branch_target_buffer i_branch_target_buffer (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .next_pc(next_pc),
      .pred_hit(pred_hit), .upd_valid(upd_valid), .upd_pc(upd_pc),
      .upd_target(upd_target), .upd_taken(upd_taken)
   );

   function automatic int slot_of(input logic [PC_W-1:0] pc);
      return int'((pc >> 2) % SLOTS);
   endfunction

   task automatic check_out(input string req);
      int s;
      bit exp_hit;
      logic [PC_W-1:0] exp_pc;
      s = slot_of(fetch_pc);
      exp_hit = m_v[s] && (m_tag[s] == fetch_pc);
      exp_pc = exp_hit ? m_tgt[s] : fetch_pc + 4;
      n_checks++;
      if (pred_hit !== exp_hit || next_pc !== exp_pc) begin
         n_fail++;
         $display("FAIL %s: pc=%h hit=%b next=%h expected hit=%b next=%h",
                  req, fetch_pc, pred_hit, next_pc, exp_hit, exp_pc);
      end
   endtask

   // one cycle: drive, compare, then advance the model past the edge
   task automatic step(input logic [PC_W-1:0] fpc, input bit uv,
                       input logic [PC_W-1:0] upc, input logic [PC_W-1:0] utg,
                       input bit utk, input string req);
      int s;
      @(negedge clk);
      fetch_pc = fpc; upd_valid = uv; upd_pc = upc; upd_target = utg; upd_taken = utk;
      #1;
      check_out(req);
      @(posedge clk);
      if (uv) begin
         s = slot_of(upc);
         if (utk) begin
            m_v[s] = 1; m_tag[s] = upc; m_tgt[s] = utg;
         end else if (m_v[s] && m_tag[s] == upc) begin
            m_v[s] = 0;
         end
      end
   endtask

   task automatic look(input logic [PC_W-1:0] fpc, input string req);
      step(fpc, 0, 32'h0, 32'h0, 0, req);
   endtask

   initial begin
      #(8 * 100000);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      if (!done) begin
         $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < SLOTS; i++) begin m_v[i] = 0; m_tag[i] = '0; m_tgt[i] = '0; end
      // R1: misses while in reset, updates ignored by reset
      @(negedge clk); fetch_pc = 32'h100; #1; check_out("R1");
      @(negedge clk); fetch_pc = 32'h2c; #1; check_out("R1");
      @(negedge clk); rst_n = 1'b1;
      look(32'h100, "R1");
      look(32'h3c, "R1");
      // R2: sequential fall-through on several addresses
      look(32'h0, "R2");
      look(32'hfffffffc, "R2");
      look(32'h1234, "R2");
      // R3: allocate then hit
      step(32'h0, 1, 32'h100, 32'h400, 1, "R3");
      look(32'h100, "R3");
      look(32'h104, "R3");
      // R4: alias 0x140 shares slot 0 with 0x100, different tag
      look(32'h140, "R4");
      look(32'h10100, "R4");
      // R5: replace slot with 0x140
      step(32'h0, 1, 32'h140, 32'h800, 1, "R5");
      look(32'h100, "R5");
      look(32'h140, "R5");
      // R6: not-taken clears matching entry
      step(32'h0, 1, 32'h140, 32'h0, 0, "R6");
      look(32'h140, "R6");
      // R7: not-taken with other tag in same slot keeps entry
      step(32'h0, 1, 32'h200, 32'h600, 1, "R7");
      step(32'h0, 1, 32'h240, 32'h0, 0, "R7");
      look(32'h200, "R7");
      // R8: same-cycle lookup and update return old contents
      step(32'h300, 1, 32'h300, 32'h900, 1, "R8");
      look(32'h300, "R8");
      step(32'h300, 1, 32'h300, 32'h0, 0, "R8");
      look(32'h300, "R8");
      step(32'h200, 1, 32'h200, 32'ha00, 1, "R8");
      look(32'h200, "R8");
      // R9: update ignored without upd_valid
      step(32'h0, 0, 32'h380, 32'hb00, 1, "R9");
      look(32'h380, "R9");
      step(32'h0, 0, 32'h200, 32'h0, 0, "R9");
      look(32'h200, "R9");
      // mixed random traffic over a small aligned pool
      for (int i = 0; i < 400; i++) begin
         logic [PC_W-1:0] a, b, t;
         a = {24'h0, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)), 2'b00};
         b = {24'h0, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)), 2'b00};
         t = {16'h0, 14'($urandom), 2'b00};
         step(a, $urandom_range(0, 1) == 1, b, t, $urandom_range(0, 2) != 0, "R3_R5_R6_mix");
      end
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule